// File: doc/BRIEF.md
# Privileged Trap Entry and Return Sequencer

This block steers a simple 64-bit core into and out of its privileged mode. When the core reports a fault or trap, the block records where execution should resume. It then redirects fetch to a privileged entry point, computed as a base address plus an offset chosen by the kind of trap. A return-from-exception command sends fetch back to the recorded address. Bit 0 of that address decides whether the core stays privileged after the return.

While the core is privileged, a shadow bank stands in for a fixed group of integer registers: registers 8 to 14 and register 25. Every other register is the same storage in both modes. The block holds the integer register array with one write port and one read port, so the effect of the bank swap can be seen from outside.

Trap requests arrive on a valid/ready stream. Return commands arrive on a second valid/ready stream. The trap stream is always ready. A trap and a return in the same cycle cannot both be taken: the trap wins, and the return stream drops ready for that cycle. A return that is not accepted has no effect, and the source must hold it until ready is high. The register ports, the outputs and the base address are plain signals.

Top module: `priv_trap_seq`

## Requirements
- R1: Synchronous active-low reset puts the block in this state:
  - privileged mode is on and the shadow bank is in use;
  - `pc` = `priv_base` + 0x001 and `npc` = `pc` + 4;
  - `exc_addr` = 0;
  - all registers read 0;
  - the `redirect`, `illegal_op`, `rearm_intr` and `swap_err` pulses are low.
- R2: An accepted trap loads `exc_addr` with `evt_pc`. The one exception is an interrupt (kind code 2) taken while already privileged, which leaves `exc_addr` unchanged.
- R3: For a privileged call (kind 3) or an arithmetic trap (kind 4), the saved address is `evt_pc` + 4.
- R4: One cycle after a trap is accepted:
  - `pc` = `priv_base` + offset, and `npc` = `pc` + 4;
  - privileged mode is on, and `redirect` pulses for one cycle.
  - The offset is selected by the kind code:

    | Kind | Code | Offset |
    |---|---|---|
    | machine check | 0 | 0x401 |
    | alignment | 1 | 0x301 |
    | interrupt | 2 | 0x101 |
    | privileged call | 3 | 0x2001 |
    | arithmetic | 4 | 0x501 |
    | illegal opcode | 5 | 0x7C1 |
    | codes 6 and 7 | 6, 7 | 0x401 (treated as machine check) |
- R5: The shadow bank is switched in by a trap only when the core was not privileged at entry. The bank is in use exactly while privileged mode is on.
- R6: Registers 8 to 14 and 25 have separate privileged copies. Register 25 uses shadow slot 7, and register n (8 to 14) uses slot n-8. All other registers are shared between modes. A read or write in a given cycle uses the bank selected before that cycle's edge.
- R7: An accepted return while not privileged pulses `illegal_op` one cycle later. It changes nothing else.
- R8: An accepted return while privileged does the following one cycle later:
  - sets `npc` to `exc_addr` and leaves `pc` unchanged;
  - pulses `redirect` and `rearm_intr`;
  - leaves privileged mode and switches the bank out only if bit 0 of `exc_addr` is 0.
- R9: `evt_ready` is always 1. `ret_ready` is the inverse of `evt_valid`.
- R10: A request to swap the bank into the state it is already in pulses `swap_err` and leaves the bank unchanged. The sequencer never issues such a request, so under any legal input sequence `swap_err` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| priv_base | input | 64 | Base address of privileged entry points |
| evt_valid | input | 1 | Trap request valid |
| evt_ready | output | 1 | Trap request ready (always 1) |
| evt_kind | input | 3 | Trap kind code |
| evt_pc | input | 64 | PC of the trapping instruction |
| ret_valid | input | 1 | Return-from-exception valid |
| ret_ready | output | 1 | Return-from-exception ready |
| rf_we | input | 1 | Register write enable |
| rf_waddr | input | 5 | Register write index |
| rf_wdata | input | 64 | Register write data |
| rf_raddr | input | 5 | Register read index |
| rf_rdata | output | 64 | Register read data (combinational) |
| pc | output | 64 | Current fetch PC |
| npc | output | 64 | Next fetch PC |
| exc_addr | output | 64 | Saved exception address |
| priv_mode | output | 1 | Privileged mode flag |
| redirect | output | 1 | One-cycle pulse when the PCs were redirected |
| illegal_op | output | 1 | One-cycle pulse: return issued outside privileged mode |
| rearm_intr | output | 1 | One-cycle pulse: interrupt checking re-armed |
| swap_err | output | 1 | One-cycle pulse: bank swap into the current state |

## Verification
Some properties are checked by assertions on every cycle:
- the bank tracks the mode flag;
- a trap always lands in privileged mode;
- calls and arithmetic traps skip the faulting instruction;
- an interrupt taken while privileged keeps the saved address;
- the outcome of a return in each mode;
- a redundant swap is ignored;
- the return stream yields to a trap.

Two things are left to the bench scenarios. The first is the data-path consequence of the bank swap: which physical copy a register index reads after a sequence of entries and returns. The second is the exact target addresses for each trap kind and base value. These are compared every cycle against the bench's behavioural model, over both directed and random sequences.

// File: rtl/trapseq_pkg.sv
package trapseq_pkg;

  typedef enum logic [2:0] {
    K_MCHK  = 3'd0,
    K_ALIGN = 3'd1,
    K_INTR  = 3'd2,
    K_CALL  = 3'd3,
    K_ARITH = 3'd4,
    K_ILLOP = 3'd5
  } trap_kind_e;

  localparam int unsigned VEC_W      = 16;
  localparam logic [VEC_W-1:0] VEC_RESET = 16'h0001;
  localparam int unsigned BANK_LO    = 8;
  localparam int unsigned BANK_HI    = 14;
  localparam int unsigned BANK_EXTRA = 25;
  localparam int unsigned NSHADOW    = BANK_HI - BANK_LO + 2;
  localparam int unsigned SLOT_W     = $clog2(NSHADOW);

  function automatic logic is_banked(int unsigned idx);
    return ((idx >= BANK_LO) && (idx <= BANK_HI)) || (idx == BANK_EXTRA);
  endfunction

  function automatic int unsigned shadow_slot(int unsigned idx);
    return (idx == BANK_EXTRA) ? (NSHADOW - 1) : (idx - BANK_LO);
  endfunction

endpackage

// File: rtl/trapseq_vec.sv
module trapseq_vec
  import trapseq_pkg::*;
#(
  parameter int unsigned XLEN = 64
) (
  input  logic [2:0]      kind,
  output logic [XLEN-1:0] offset,
  output logic            skip_insn
);
  logic [VEC_W-1:0] vec;

  always_comb begin
    case (trap_kind_e'(kind))
      K_ALIGN: vec = 16'h0301;
      K_INTR:  vec = 16'h0101;
      K_CALL:  vec = 16'h2001;
      K_ARITH: vec = 16'h0501;
      K_ILLOP: vec = 16'h07C1;
      default: vec = 16'h0401;
    endcase
  end

  assign offset    = XLEN'(vec);
  assign skip_insn = (kind == K_CALL) || (kind == K_ARITH);

endmodule

// File: rtl/trapseq_shadow_rf.sv
module trapseq_shadow_rf
  import trapseq_pkg::*;
#(
  parameter int unsigned XLEN  = 64,
  parameter int unsigned NREGS = 32,
  localparam int unsigned AW   = $clog2(NREGS)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            swap_req,
  input  logic            swap_to,
  output logic            shadow_on,
  output logic            swap_err,
  input  logic            we,
  input  logic [AW-1:0]   waddr,
  input  logic [XLEN-1:0] wdata,
  input  logic [AW-1:0]   raddr,
  output logic [XLEN-1:0] rdata
);
  logic [XLEN-1:0] main_q [NREGS];
  logic [XLEN-1:0] shad_q [NSHADOW];
  logic            shadow_q;
  logic            err_q;
  logic            w_banked;
  logic            r_banked;
  logic [SLOT_W-1:0] w_slot;
  logic [SLOT_W-1:0] r_slot;

  assign w_banked = is_banked(int'(waddr)) && shadow_q;
  assign r_banked = is_banked(int'(raddr)) && shadow_q;
  assign w_slot   = SLOT_W'(shadow_slot(int'(waddr)));
  assign r_slot   = SLOT_W'(shadow_slot(int'(raddr)));

  for (genvar g = 0; g < NREGS; g++) begin : g_main
    always_ff @(posedge clk) begin
      if (!rst_n) main_q[g] <= '0;
      else if (we && !w_banked && (waddr == AW'(g))) main_q[g] <= wdata;
    end
  end

  for (genvar s = 0; s < NSHADOW; s++) begin : g_shad
    always_ff @(posedge clk) begin
      if (!rst_n) shad_q[s] <= '0;
      else if (we && w_banked && (w_slot == SLOT_W'(s))) shad_q[s] <= wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shadow_q <= 1'b1;
      err_q    <= 1'b0;
    end else begin
      err_q <= swap_req && (swap_to == shadow_q);
      if (swap_req && (swap_to != shadow_q)) shadow_q <= swap_to;
    end
  end

  assign rdata     = r_banked ? shad_q[r_slot] : main_q[raddr];
  assign shadow_on = shadow_q;
  assign swap_err  = err_q;

  assert_swap_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (swap_req && (swap_to == shadow_on)) |=> (swap_err && (shadow_on == $past(shadow_on))));

endmodule

// File: rtl/priv_trap_seq.sv
module priv_trap_seq
  import trapseq_pkg::*;
#(
  parameter int unsigned XLEN  = 64,
  parameter int unsigned NREGS = 32,
  localparam int unsigned AW   = $clog2(NREGS)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [XLEN-1:0] priv_base,
  input  logic            evt_valid,
  output logic            evt_ready,
  input  logic [2:0]      evt_kind,
  input  logic [XLEN-1:0] evt_pc,
  input  logic            ret_valid,
  output logic            ret_ready,
  input  logic            rf_we,
  input  logic [AW-1:0]   rf_waddr,
  input  logic [XLEN-1:0] rf_wdata,
  input  logic [AW-1:0]   rf_raddr,
  output logic [XLEN-1:0] rf_rdata,
  output logic [XLEN-1:0] pc,
  output logic [XLEN-1:0] npc,
  output logic [XLEN-1:0] exc_addr,
  output logic            priv_mode,
  output logic            redirect,
  output logic            illegal_op,
  output logic            rearm_intr,
  output logic            swap_err
);
  localparam logic [XLEN-1:0] STEP = XLEN'(4);

  logic [XLEN-1:0] pc_q, npc_q, exc_q;
  logic            priv_q, redir_q, illeg_q, rearm_q;
  logic [XLEN-1:0] vec_off;
  logic            skip;
  logic            evt_fire, ret_fire;
  logic            keep_exc;
  logic            swap_req, swap_to, shadow_on;
  logic [XLEN-1:0] target;

  trapseq_vec #(.XLEN(XLEN)) u_vec (
    .kind(evt_kind), .offset(vec_off), .skip_insn(skip)
  );

  assign evt_ready = 1'b1;
  assign ret_ready = !evt_valid;
  assign evt_fire  = evt_valid;
  assign ret_fire  = ret_valid && ret_ready;
  assign keep_exc  = (evt_kind == K_INTR) && priv_q;
  assign target    = priv_base + vec_off;

  assign swap_req = (evt_fire && !priv_q) || (ret_fire && priv_q && !exc_q[0]);
  assign swap_to  = evt_fire;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      priv_q  <= 1'b1;
      pc_q    <= priv_base + XLEN'(VEC_RESET);
      npc_q   <= priv_base + XLEN'(VEC_RESET) + STEP;
      exc_q   <= '0;
      redir_q <= 1'b0;
      illeg_q <= 1'b0;
      rearm_q <= 1'b0;
    end else begin
      redir_q <= 1'b0;
      illeg_q <= 1'b0;
      rearm_q <= 1'b0;
      if (evt_fire) begin
        if (!keep_exc) exc_q <= evt_pc + (skip ? STEP : '0);
        priv_q  <= 1'b1;
        pc_q    <= target;
        npc_q   <= target + STEP;
        redir_q <= 1'b1;
      end else if (ret_fire) begin
        if (priv_q) begin
          npc_q   <= exc_q;
          redir_q <= 1'b1;
          rearm_q <= 1'b1;
          if (!exc_q[0]) priv_q <= 1'b0;
        end else begin
          illeg_q <= 1'b1;
        end
      end
    end
  end

  trapseq_shadow_rf #(.XLEN(XLEN), .NREGS(NREGS)) u_rf (
    .clk(clk), .rst_n(rst_n),
    .swap_req(swap_req), .swap_to(swap_to),
    .shadow_on(shadow_on), .swap_err(swap_err),
    .we(rf_we), .waddr(rf_waddr), .wdata(rf_wdata),
    .raddr(rf_raddr), .rdata(rf_rdata)
  );

  assign pc         = pc_q;
  assign npc        = npc_q;
  assign exc_addr   = exc_q;
  assign priv_mode  = priv_q;
  assign redirect   = redir_q;
  assign illegal_op = illeg_q;
  assign rearm_intr = rearm_q;

  assert_bank_tracks_mode_R5: assert property (@(posedge clk) disable iff (!rst_n)
    shadow_on == priv_mode);
  assert_trap_enters_priv_R4: assert property (@(posedge clk) disable iff (!rst_n)
    evt_valid |=> (priv_mode && redirect && (npc == pc + STEP)));
  assert_skip_saved_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_valid && ((evt_kind == K_CALL) || (evt_kind == K_ARITH)))
      |=> (exc_addr == $past(evt_pc) + STEP));
  assert_intr_keeps_exc_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_valid && (evt_kind == K_INTR) && priv_mode) |=> $stable(exc_addr));
  assert_ret_outside_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_valid && !evt_valid && !priv_mode) |=> (illegal_op && !redirect && !priv_mode));
  assert_ret_exit_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_valid && !evt_valid && priv_mode && !exc_addr[0])
      |=> (!priv_mode && rearm_intr && (npc == $past(exc_addr))));
  assert_ret_backpressure_R9: assert property (@(posedge clk) disable iff (!rst_n)
    evt_valid |-> (!ret_ready && evt_ready));

endmodule

// File: tb/priv_trap_seq_test.sv
module priv_trap_seq_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [63:0] priv_base;
  logic        evt_valid, evt_ready;
  logic [2:0]  evt_kind;
  logic [63:0] evt_pc;
  logic        ret_valid, ret_ready;
  logic        rf_we;
  logic [4:0]  rf_waddr, rf_raddr;
  logic [63:0] rf_wdata, rf_rdata;
  logic [63:0] pc, npc, exc_addr;
  logic        priv_mode, redirect, illegal_op, rearm_intr, swap_err;

  always #10 clk = ~clk;

  priv_trap_seq uut (
    .clk(clk), .rst_n(rst_n), .priv_base(priv_base),
    .evt_valid(evt_valid), .evt_ready(evt_ready), .evt_kind(evt_kind), .evt_pc(evt_pc),
    .ret_valid(ret_valid), .ret_ready(ret_ready),
    .rf_we(rf_we), .rf_waddr(rf_waddr), .rf_wdata(rf_wdata),
    .rf_raddr(rf_raddr), .rf_rdata(rf_rdata),
    .pc(pc), .npc(npc), .exc_addr(exc_addr), .priv_mode(priv_mode),
    .redirect(redirect), .illegal_op(illegal_op), .rearm_intr(rearm_intr),
    .swap_err(swap_err)
  );

  int total = 0;
  int fails = 0;
  bit timed_out = 0;

  // behavioural reference
  logic [63:0] m_main [32];
  logic [63:0] m_shad [8];
  logic [63:0] m_pc, m_npc, m_exc;
  bit m_priv, m_redir, m_illeg, m_rearm;

  function automatic logic [63:0] vec_ref(logic [2:0] k);
    case (k)
      3'd1: return 64'h301;
      3'd2: return 64'h101;
      3'd3: return 64'h2001;
      3'd4: return 64'h501;
      3'd5: return 64'h7C1;
      default: return 64'h401;
    endcase
  endfunction

  function automatic bit banked(logic [4:0] i);
    return (i >= 8 && i <= 14) || i == 25;
  endfunction

  function automatic int slot(logic [4:0] i);
    return (i == 25) ? 7 : int'(i) - 8;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 32; i++) m_main[i] = 0;
      for (int i = 0; i < 8; i++) m_shad[i] = 0;
      m_priv = 1; m_pc = priv_base + 64'h1; m_npc = m_pc + 4; m_exc = 0;
      m_redir = 0; m_illeg = 0; m_rearm = 0;
    end else begin
      if (rf_we) begin
        if (banked(rf_waddr) && m_priv) m_shad[slot(rf_waddr)] = rf_wdata;
        else m_main[rf_waddr] = rf_wdata;
      end
      m_redir = 0; m_illeg = 0; m_rearm = 0;
      if (evt_valid) begin
        if (!(evt_kind == 3'd2 && m_priv))
          m_exc = evt_pc + ((evt_kind == 3'd3 || evt_kind == 3'd4) ? 64'd4 : 64'd0);
        m_priv = 1;
        m_pc = priv_base + vec_ref(evt_kind);
        m_npc = m_pc + 4;
        m_redir = 1;
      end else if (ret_valid) begin
        if (m_priv) begin
          m_npc = m_exc; m_redir = 1; m_rearm = 1;
          if (!m_exc[0]) m_priv = 0;
        end else m_illeg = 1;
      end
    end
  end

  task automatic chk(string req, string what, logic [63:0] got, logic [63:0] exp);
    total++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, got, exp);
    end
  endtask

  task automatic compare_all();
    logic [63:0] rexp;
    rexp = (banked(rf_raddr) && m_priv) ? m_shad[slot(rf_raddr)] : m_main[rf_raddr];
    chk("R4", "pc", pc, m_pc);
    chk("R8", "npc", npc, m_npc);
    chk("R2", "exc_addr", exc_addr, m_exc);
    chk("R5", "priv_mode", {63'd0, priv_mode}, {63'd0, m_priv});
    chk("R4", "redirect", {63'd0, redirect}, {63'd0, m_redir});
    chk("R7", "illegal_op", {63'd0, illegal_op}, {63'd0, m_illeg});
    chk("R8", "rearm_intr", {63'd0, rearm_intr}, {63'd0, m_rearm});
    chk("R10", "swap_err", {63'd0, swap_err}, 64'd0);
    chk("R6", "rf_rdata", rf_rdata, rexp);
    chk("R9", "evt_ready", {63'd0, evt_ready}, 64'd1);
    chk("R9", "ret_ready", {63'd0, ret_ready}, {63'd0, !evt_valid});
  endtask

  task automatic tick();
    @(negedge clk);
    compare_all();
  endtask

  task automatic idle();
    evt_valid = 0; ret_valid = 0; rf_we = 0;
  endtask

  task automatic wr(logic [4:0] a, logic [63:0] d);
    idle(); rf_we = 1; rf_waddr = a; rf_wdata = d; tick(); rf_we = 0;
  endtask

  task automatic trap(logic [2:0] k, logic [63:0] p);
    idle(); evt_valid = 1; evt_kind = k; evt_pc = p; tick(); evt_valid = 0;
  endtask

  task automatic ret();
    idle(); ret_valid = 1; tick(); ret_valid = 0;
  endtask

  task automatic run();
    idle(); rst_n = 0; priv_base = 64'h0000_0000_0010_0000;
    evt_kind = 0; evt_pc = 0; rf_waddr = 0; rf_wdata = 0; rf_raddr = 0;
    repeat (3) tick();
    rst_n = 1;
    // R1: reset values at the ports
    chk("R1", "reset pc", pc, 64'h0010_0001);
    chk("R1", "reset npc", npc, 64'h0010_0005);
    chk("R1", "reset priv", {63'd0, priv_mode}, 64'd1);
    // R6: privileged copies of 9 and 25, shared 3
    wr(5'd9, 64'hAAAA); wr(5'd25, 64'hCCCC); wr(5'd3, 64'hBBBB);
    ret();                                    // exc_addr=0, bit0=0: leave
    chk("R8", "exit priv", {63'd0, priv_mode}, 64'd0);
    wr(5'd9, 64'hDDDD); wr(5'd3, 64'hEEEE);
    idle(); rf_raddr = 5'd9; tick();
    chk("R6", "user r9", rf_rdata, 64'hDDDD);
    trap(3'd3, 64'h1000);                     // R3 call: skip
    chk("R3", "call exc", exc_addr, 64'h1004);
    chk("R4", "call pc", pc, 64'h0010_2001);
    rf_raddr = 5'd9; tick();
    chk("R6", "priv r9", rf_rdata, 64'hAAAA);
    rf_raddr = 5'd3; tick();
    chk("R6", "shared r3", rf_rdata, 64'hEEEE);
    trap(3'd2, 64'h2000);                     // R2 interrupt while privileged
    chk("R2", "intr keep exc", exc_addr, 64'h1004);
    trap(3'd1, 64'h3000);
    chk("R2", "align exc", exc_addr, 64'h3000);
    chk("R4", "align pc", pc, 64'h0010_0301);
    ret(); ret();                             // second one is outside
    chk("R7", "illegal pulse", {63'd0, illegal_op}, 64'd1);
    idle(); evt_valid = 1; ret_valid = 1; evt_kind = 3'd0; evt_pc = 64'h4001; tick();
    chk("R9", "trap wins", {63'd0, rearm_intr}, 64'd0);
    idle(); ret();                            // exc bit0=1: stay privileged
    chk("R8", "stay priv", {63'd0, priv_mode}, 64'd1);
    chk("R8", "ret npc", npc, 64'h4001);
    trap(3'd4, 64'h5000);
    chk("R3", "arith exc", exc_addr, 64'h5004);
    trap(3'd5, 64'h6000); trap(3'd7, 64'h7000);
    chk("R4", "kind7 pc", pc, 64'h0010_0401);
    for (int n = 0; n < 2000; n++) begin
      evt_valid = ($urandom % 5) == 0;
      ret_valid = ($urandom % 4) == 0;
      evt_kind  = 3'($urandom);
      evt_pc    = {$urandom, $urandom};
      rf_we     = $urandom % 2;
      rf_waddr  = 5'($urandom);
      rf_wdata  = {$urandom, $urandom};
      rf_raddr  = ($urandom % 2) ? 5'd8 + 5'($urandom % 7) : 5'($urandom);
      if (($urandom % 50) == 0) priv_base = {32'd0, $urandom} & ~64'hFFFF;
      rst_n = ($urandom % 400) != 0;
      tick();
    end
    idle(); rst_n = 1; tick();
  endtask

  initial begin
    fork
      run();
      begin repeat (100000) @(posedge clk); timed_out = 1; end
    join_any
    disable fork;
    if (timed_out) begin
      total++; fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
    end
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

endmodule